// File: doc/BRIEF.md
# Sequencer Instruction RAM Download Port

This block is the host-facing loader for the instruction store of a small microsequencer. A byte-wide host bus reaches five registers through a 3-bit select: a control register, a one-byte data window into the instruction RAM, a low and a high address register, and a sticky hard-error register. Host software loads a program by doing three things in order. It enables loading. It sets the word address. It then streams each 32-bit instruction through the data window as four byte writes, least significant byte first.

The first three bytes of a word are held in a staging register. The fourth byte commits the whole word to RAM and advances the word address by one. Each byte is stored with an odd-parity bit. Reading the window returns the selected byte of the committed word and checks its parity. A restart bit in the control register sends the sequencer back to address zero. Software then polls the two address registers until both read zero. Instruction execution itself is not modelled. An output flag shows whether the sequencer would be running, which is the case whenever loading is off.

Top module: `seq_ram_loader`

## Requirements
- R1: Select values are: 0 control, 1 data window, 2 address low, 3 address high, 4 hard error. After reset, all five read as 0x00 and the RAM holds all-zero words with all-zero parity bits.
- R2: The control register reads back the last value written, except that bit 1 always reads 0. Bit 0 enables loading, bit 1 requests a restart and bit 7 disables parity checking. Bits 2 to 6 are stored with no effect. `seq_running` equals the inverse of control bit 0.
- R3: With loading enabled, writes to the data window fill byte lanes 0, 1, 2, 3 in turn. The write to lane 3 commits {lane3, lane2, lane1, lane0} to the RAM at the current address. The address increments only after that lane-3 write, and it wraps from 511 to 0.
- R4: The word address is 9 bits. The address-low register holds bits 7:0. Only bit 0 of the address-high register is address bit 8, and its upper seven bits read 0. Writing either address register returns the lane to 0.
- R5: Writing control with bit 1 set makes the address read 0 on the next cycle and resets the lane to 0.
- R6: With control bit 0 clear, a data-window write changes neither the RAM, the lane nor the address. A data-window read returns the byte but has no side effect.
- R7: A data-window read returns byte [lane] of the committed word at the current address. With loading enabled, reads advance the lane and the address exactly as writes do.
- R8: Hard-error bits are: bit 0 illegal host access, bit 1 illegal sequencer address, bit 2 illegal opcode (never set here), bit 3 RAM parity error. The bits are sticky. Writing 1 to a bit clears it. Bits 7:4 read 0.
- R9: A read or write with a select value of 5, 6 or 7 sets hard-error bit 0. Such reads return 0x00.
- R10: With loading enabled, any data-window access while the address is at or above DEPTH (448 by default) sets hard-error bit 1. A commit at such an address is dropped, and reads there return 0x00.
- R11: With control bit 7 clear and loading enabled, a data-window read whose stored byte and parity bit have even combined parity sets hard-error bit 3. This happens, for example, on any never-loaded word. With bit 7 set, no such read sets the bit. A loaded word never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (ignored while host_wr is high) |
| host_sel | input | 3 | Register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the selected register (combinational) |
| seq_running | output | 1 | High when loading is disabled |

## Verification
Directed sequences cover several distinct patterns. Full four-byte words are loaded and read back, which separates lane order from commit timing. Partial words are interrupted by an address write, which shows the lane clear. Restart writes made in mid-word are also tried. Accesses while loading is disabled, just above DEPTH and at the 511 wrap exercise the boundary rules. Reads of unloaded words with parity checking on and off separate the check from its disable bit. A long seeded random mix then interleaves every select value, and each read is compared with a bench model of the register map and RAM.

// File: rtl/seq_ram_loader.sv
module seq_ram_loader #(
  parameter int DEPTH = 448
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [2:0] host_sel,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       seq_running
);
  localparam int AW    = 9;
  localparam int LANES = 4;
  localparam int SLOT  = 9;
  localparam int WW    = LANES * SLOT;

  localparam logic [2:0] S_CTRL = 3'd0;
  localparam logic [2:0] S_DATA = 3'd1;
  localparam logic [2:0] S_ALO  = 3'd2;
  localparam logic [2:0] S_AHI  = 3'd3;
  localparam logic [2:0] S_ERR  = 3'd4;

  logic [7:0]    ctrl_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    lane_q;
  logic [23:0]   stage_q;
  logic [3:0]    err_q;
  logic [WW-1:0] mem [DEPTH];

  logic          rd_go, load_en, in_range, wr_data, rd_data, step, commit;
  logic          ill_host, ill_seq, par_err;
  logic [WW-1:0] word, new_word;
  logic [SLOT-1:0] slot;
  logic [3:0]    err_clr;

  assign load_en     = ctrl_q[0];
  assign seq_running = ~ctrl_q[0];
  assign rd_go       = host_rd & ~host_wr;
  assign in_range    = 32'(addr_q) < DEPTH;
  assign word        = in_range ? mem[addr_q] : '0;
  assign slot        = word[lane_q*SLOT +: SLOT];

  assign wr_data  = host_wr & (host_sel == S_DATA) & load_en;
  assign rd_data  = rd_go & (host_sel == S_DATA) & load_en;
  assign step     = wr_data | rd_data;
  assign commit   = wr_data & (lane_q == 2'd3) & in_range;

  assign ill_host = (host_wr | rd_go) & (host_sel > S_ERR);
  assign ill_seq  = step & ~in_range;
  assign par_err  = rd_data & in_range & ~ctrl_q[7] & ~(^slot);
  assign err_clr  = (host_wr && host_sel == S_ERR) ? host_wdata[3:0] : 4'd0;

  assign new_word = {~^host_wdata,    host_wdata,
                     ~^stage_q[23:16], stage_q[23:16],
                     ~^stage_q[15:8],  stage_q[15:8],
                     ~^stage_q[7:0],   stage_q[7:0]};

  always_comb begin
    case (host_sel)
      S_CTRL:  host_rdata = ctrl_q;
      S_DATA:  host_rdata = slot[7:0];
      S_ALO:   host_rdata = addr_q[7:0];
      S_AHI:   host_rdata = {7'd0, addr_q[8]};
      S_ERR:   host_rdata = {4'd0, err_q};
      default: host_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      lane_q  <= '0;
      stage_q <= '0;
      err_q   <= '0;
    end else begin
      err_q <= (err_q & ~err_clr) | {par_err, 1'b0, ill_seq, ill_host};
      if (host_wr) begin
        case (host_sel)
          S_CTRL: begin
            ctrl_q <= host_wdata & 8'hFD;
            if (host_wdata[1]) begin
              addr_q <= '0;
              lane_q <= '0;
            end
          end
          S_ALO: begin
            addr_q[7:0] <= host_wdata;
            lane_q      <= '0;
          end
          S_AHI: begin
            addr_q[8] <= host_wdata[0];
            lane_q    <= '0;
          end
          default: ;
        endcase
      end
      if (wr_data && lane_q != 2'd3)
        stage_q[lane_q*8 +: 8] <= host_wdata;
      if (step) begin
        lane_q <= lane_q + 2'd1;
        if (lane_q == 2'd3) addr_q <= addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[addr_q] <= new_word;
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == S_CTRL && host_wdata[1] |=> addr_q == '0 && lane_q == '0); // R5
  AST_LOAD_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_sel == S_DATA && !ctrl_q[0] |=> $stable(addr_q) && $stable(lane_q)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && lane_q == 2'd3 |=> addr_q == AW'($past(addr_q) + 1'b1)); // R3
  AST_ADDR_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && lane_q != 2'd3 |=> $stable(addr_q)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_sel == S_ERR) |=> (err_q & $past(err_q)) == $past(err_q)); // R8
  AST_NO_OPCODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_q[2] == 1'b0); // R8
  AST_OOR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    step && !in_range |=> err_q[1]); // R10
endmodule

// File: tb/test_seq_ram_loader.sv
`timescale 1ns/1ps
module test_seq_ram_loader;
  localparam int DEPTH = 448;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       host_wr = 0, host_rd = 0;
  logic [2:0] host_sel = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       seq_running;

  int checks = 0, errors = 0;

  logic [31:0] m_mem [512];
  bit          m_wr  [512];
  logic [7:0]  m_ctrl;
  logic [8:0]  m_addr;
  logic [1:0]  m_lane;
  logic [23:0] m_stage;
  logic [3:0]  m_err;

  always #10 clk = ~clk;

  seq_ram_loader #(.DEPTH(DEPTH)) i_seq_ram_loader (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .seq_running(seq_running));

  function automatic logic [7:0] exp_read(int sel);
    case (sel)
      0: return m_ctrl;
      1: return (m_addr < DEPTH && m_wr[m_addr]) ? m_mem[m_addr][m_lane*8 +: 8] : 8'd0;
      2: return m_addr[7:0];
      3: return {7'd0, m_addr[8]};
      4: return {4'd0, m_err};
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic op(bit wr, int sel, logic [7:0] d, string req);
    logic [7:0] e;
    bit step;
    e = exp_read(sel);
    @(negedge clk);
    host_wr = wr; host_rd = !wr; host_sel = 3'(sel); host_wdata = d;
    #2;
    if (!wr) check(req, host_rdata, e);
    step = (sel == 1) && m_ctrl[0];
    if (sel > 4) m_err[0] = 1'b1;
    if (step && m_addr >= DEPTH) m_err[1] = 1'b1;
    if (!wr && step && m_addr < DEPTH && !m_wr[m_addr] && !m_ctrl[7]) m_err[3] = 1'b1;
    if (wr) begin
      case (sel)
        0: begin m_ctrl = d & 8'hFD; if (d[1]) begin m_addr = 0; m_lane = 0; end end
        1: if (m_ctrl[0]) begin
             if (m_lane != 3) m_stage[m_lane*8 +: 8] = d;
             else if (m_addr < DEPTH) begin m_mem[m_addr] = {d, m_stage}; m_wr[m_addr] = 1; end
           end
        2: begin m_addr[7:0] = d; m_lane = 0; end
        3: begin m_addr[8] = d[0]; m_lane = 0; end
        4: m_err = m_err & ~d[3:0];
        default: ;
      endcase
    end
    if (step) begin
      if (m_lane == 3) m_addr = m_addr + 1;
      m_lane = m_lane + 1;
    end
    @(posedge clk);
  endtask

  task automatic set_addr(int a);
    op(1, 3, 8'(a >> 8), "R4");
    op(1, 2, 8'(a), "R4");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_ctrl = 0; m_addr = 0; m_lane = 0; m_stage = 0; m_err = 0;
    for (int i = 0; i < 512; i++) begin m_mem[i] = 0; m_wr[i] = 0; end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    for (int s = 0; s < 5; s++) op(0, s, 0, "R1");
    @(negedge clk); check("R2 running", {7'd0, seq_running}, 8'd1);

    op(1, 0, 8'hFF, "R2"); op(0, 0, 0, "R2");
    @(negedge clk); check("R2 running", {7'd0, seq_running}, 8'd0);

    op(1, 0, 8'h01, "R3"); set_addr(5);
    op(1, 1, 8'h11, "R3"); op(1, 1, 8'h22, "R3"); op(1, 1, 8'h33, "R3");
    op(0, 2, 0, "R3");
    op(1, 1, 8'h44, "R3"); op(0, 2, 0, "R3");
    set_addr(5);
    for (int k = 0; k < 4; k++) op(0, 1, 0, "R7");
    op(0, 2, 0, "R7");

    set_addr(9); op(1, 1, 8'h5A, "R4"); set_addr(9);
    for (int k = 0; k < 4; k++) op(1, 1, 8'(8'hA0 + k), "R4");
    set_addr(9); for (int k = 0; k < 4; k++) op(0, 1, 0, "R4");
    op(1, 3, 8'hFE, "R4"); op(0, 3, 0, "R4");

    op(1, 1, 8'h77, "R5"); op(1, 0, 8'h03, "R5");
    op(0, 2, 0, "R5"); op(0, 3, 0, "R5"); op(0, 0, 0, "R5");

    op(1, 0, 8'h00, "R6"); set_addr(5);
    for (int k = 0; k < 4; k++) op(1, 1, 8'hAA, "R6");
    op(0, 2, 0, "R6"); op(0, 1, 0, "R6"); op(0, 1, 0, "R6"); op(0, 2, 0, "R6");
    op(1, 0, 8'h01, "R6"); set_addr(5); op(0, 1, 0, "R6");

    op(1, 6, 8'h12, "R9"); op(0, 4, 0, "R9"); op(0, 7, 0, "R9"); op(0, 4, 0, "R9");
    op(1, 4, 8'h01, "R8"); op(0, 4, 0, "R8");

    set_addr(DEPTH);
    for (int k = 0; k < 4; k++) op(1, 1, 8'h3C, "R10");
    op(0, 4, 0, "R10"); op(0, 2, 0, "R10"); op(0, 3, 0, "R10");
    set_addr(DEPTH - 1); op(0, 4, 0, "R10");
    op(1, 4, 8'h0F, "R8"); op(0, 4, 0, "R8");
    set_addr(DEPTH); op(0, 1, 0, "R10"); op(0, 4, 0, "R10");
    op(1, 4, 8'h0F, "R8");

    set_addr(511);
    for (int k = 0; k < 4; k++) op(1, 1, 8'h01, "R3");
    op(0, 2, 0, "R3"); op(0, 3, 0, "R3");
    op(1, 4, 8'h0F, "R8");

    set_addr(32'h20); op(0, 1, 0, "R11"); op(0, 4, 0, "R11");
    op(1, 4, 8'h08, "R11"); op(1, 0, 8'h81, "R11");
    set_addr(32'h20); op(0, 1, 0, "R11"); op(0, 4, 0, "R11");
    op(1, 0, 8'h01, "R11"); set_addr(5);
    for (int k = 0; k < 4; k++) op(0, 1, 0, "R11");
    op(0, 4, 0, "R11");

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 40)      op(1, 1, 8'($urandom), "R3");
      else if (r < 60) op(0, 1, 0, "R7");
      else if (r < 66) op(1, 2, 8'($urandom), "R4");
      else if (r < 69) op(1, 3, 8'($urandom_range(0, 3) == 0), "R4");
      else if (r < 74) op(1, 0, {1'($urandom_range(0, 3) == 0), 5'($urandom),
                                 1'($urandom_range(0, 9) == 0), 1'($urandom_range(0, 7) != 0)}, "R2");
      else if (r < 78) op(0, 0, 0, "R2");
      else if (r < 84) op(0, 2, 0, "R4");
      else if (r < 87) op(0, 3, 0, "R4");
      else if (r < 94) op(0, 4, 0, "R8");
      else if (r < 97) op(1, 4, 8'($urandom), "R8");
      else if (r < 98) op(1, int'($urandom_range(5, 7)), 8'($urandom), "R9");
      else             op(0, int'($urandom_range(5, 7)), 0, "R9");
    end

    @(negedge clk); host_wr = 0; host_rd = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule